// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This block covers the modem handshake side of a serial port. A control register, written by the host, drives four active-low handshake outputs: terminal ready, request to send and two general user outputs. Four active-low handshake inputs (carrier detect, ring, data set ready and clear to send) pass through a synchronizer. They are then sampled into a status register that shows their current active-high levels next to four sticky change flags.

The change flags record any change of carrier detect, data set ready or clear to send, and a trailing edge on the ring input. A status read strobe clears all four flags. A change that lands in the same cycle as a read still sets its flag, so no event is lost. Setting the loopback bit parks the four outputs high and feeds the control bits back into the status path in place of the pins. This lets software exercise the whole status path without a modem attached. A modem-status interrupt request is raised while any flag is set and the enable input is high.

Top module: `modem_ctl_unit`

## Requirements
- R1: After reset, the control readback is 0x00, all four outputs are high, the status register reads 0x00 with all inputs inactive (high), and the interrupt request is low.
- R2: With loopback off, control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `usr1_n` and `usr2_n` low when 1 and high when 0, from the clock edge of the write. Control readback bits 7 to 5 always read 0.
- R3: Status bits 7, 6, 5 and 4 show the complements of `cd_n`, `ri_n`, `dsr_n` and `cts_n`. A pin change appears in the status after the third rising clock edge: two synchronizer stages, then one sample stage.
- R4: Status bits 3, 1 and 0 set when the sampled carrier-detect, data-set-ready or clear-to-send level (respectively) changes, in the same edge that updates the level bit.
- R5: Status bit 2 sets only when `ri_n` goes from low to high (ring level 1 to 0). `ri_n` going from high to low sets no flag.
- R6: A clock edge with `sts_rd` high clears all four change flags. A change detected at that same edge still sets its flag.
- R7: Control bit 4 enables loopback. While it is set, all four outputs are held high and the external inputs are ignored. The status levels then take terminal-ready as data set ready, request-to-send as clear to send, user output 1 as ring and user output 2 as carrier detect, one edge after the control register updates.
- R8: `msi_req` is high exactly when `msi_en` is high and at least one change flag is set.
- R9: Change flags stay set through any number of cycles without a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| sts_rd | input | 1 | Status register read strobe (clears flags) |
| sts_rdata | output | 8 | Status register: levels in 7:4, flags in 3:0 |
| msi_en | input | 1 | Modem-status interrupt enable |
| msi_req | output | 1 | Modem-status interrupt request |
| cd_n | input | 1 | Carrier detect, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| usr1_n | output | 1 | User output 1, active low |
| usr2_n | output | 1 | User output 2, active low |

## Verification
The assertions assume the four handshake pins may change at any time. They check only what follows from the synchronized levels, so they hold whatever the pin timing. They also assume `sts_rd` is a single-cycle strobe that a correct host may raise during a change. The stimulus moves pins and strobes on the falling clock edge. It holds each pin level for at least three edges so that each change reaches the status register. It also places one read exactly on the edge where a change arrives, which exercises the set-over-clear rule.

// File: rtl/modem_pkg.sv
package modem_pkg;

  localparam int LINE_CNT = 4;
  localparam int REG_W    = 8;

  // active-high view of the four handshake inputs
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  // pins_n ordered {cd_n, ri_n, dsr_n, cts_n}
  function automatic mdm_lines_t pins_to_lines(input logic [LINE_CNT-1:0] pins_n);
    return mdm_lines_t'(~pins_n);
  endfunction

  // ctl ordered {out2, out1, rts, dtr}
  function automatic mdm_lines_t loop_route(input logic [LINE_CNT-1:0] ctl);
    mdm_lines_t l;
    l.dcd = ctl[3];
    l.ri  = ctl[2];
    l.dsr = ctl[0];
    l.cts = ctl[1];
    return l;
  endfunction

  // change events ordered {ddcd, teri, ddsr, dcts}
  function automatic logic [LINE_CNT-1:0] change_events(input mdm_lines_t prev,
                                                        input mdm_lines_t now);
    return {prev.dcd ^ now.dcd,
            prev.ri & ~now.ri,
            prev.dsr ^ now.dsr,
            prev.cts ^ now.cts};
  endfunction

  // flags clear on read, but fresh events win
  function automatic logic [LINE_CNT-1:0] next_flags(input logic [LINE_CNT-1:0] cur,
                                                     input logic                rd,
                                                     input logic [LINE_CNT-1:0] evt);
    return (rd ? '0 : cur) | evt;
  endfunction

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W       = 4,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import modem_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [W-1:0]        wdata,
  output logic [W-1:0]        rdata,
  output logic [LINE_CNT-1:0] ctl_bits,
  output logic                loop_en,
  output logic [LINE_CNT-1:0] pins_n
);

  localparam int LOOP_BIT = LINE_CNT;
  localparam logic [W-1:0] KEEP_MASK = W'((1 << (LOOP_BIT + 1)) - 1);

  logic [W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (wr) ctl_q <= wdata & KEEP_MASK;
  end

  assign rdata    = ctl_q;
  assign ctl_bits = ctl_q[LINE_CNT-1:0];
  assign loop_en  = ctl_q[LOOP_BIT];

  // pins_n ordered {usr2_n, usr1_n, rts_n, dtr_n}
  genvar g;
  generate
    for (g = 0; g < LINE_CNT; g++) begin : g_drv
      assign pins_n[g] = loop_en | ~ctl_bits[g];
    end
  endgenerate

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (rdata[LINE_CNT:0] == $past(wdata[LINE_CNT:0])));

endmodule

// File: rtl/modem_sts.sv
module modem_sts
  import modem_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd,
  input  mdm_lines_t          ext_lvl,
  input  logic                loop_en,
  input  logic [LINE_CNT-1:0] loop_ctl,
  output logic [REG_W-1:0]    rdata,
  output logic [LINE_CNT-1:0] flags,
  output logic [LINE_CNT-1:0] chg_evt
);

  mdm_lines_t lvl_now;
  mdm_lines_t lvl_q;

  assign lvl_now = loop_en ? loop_route(loop_ctl) : ext_lvl;
  assign chg_evt = change_events(lvl_q, lvl_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      flags <= '0;
    end else begin
      lvl_q <= lvl_now;
      flags <= next_flags(flags, rd, chg_evt);
    end
  end

  assign rdata = {lvl_q, flags};

  // R4
  dcd_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q.dcd != $past(lvl_q.dcd)) |-> flags[3]);
  // R4
  dsr_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q.dsr != $past(lvl_q.dsr)) |-> flags[1]);
  // R4
  cts_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q.cts != $past(lvl_q.cts)) |-> flags[0]);
  // R5
  ring_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> ($past(lvl_q.ri) && !lvl_q.ri));
  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && chg_evt == '0) |=> (flags == '0));
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata,
  input  logic       msi_en,
  output logic       msi_req,
  input  logic       cd_n,
  input  logic       ri_n,
  input  logic       dsr_n,
  input  logic       cts_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       usr1_n,
  output logic       usr2_n
);

  logic [LINE_CNT-1:0] ctl_bits;
  logic                loop_en;
  logic [LINE_CNT-1:0] drv_n;
  logic [LINE_CNT-1:0] pins_sync_n;
  logic [LINE_CNT-1:0] flags;
  logic [LINE_CNT-1:0] chg_evt;

  modem_ctl_reg #(.W(REG_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .rdata    (ctl_rdata),
    .ctl_bits (ctl_bits),
    .loop_en  (loop_en),
    .pins_n   (drv_n)
  );

  assign {usr2_n, usr1_n, rts_n, dtr_n} = drv_n;

  modem_sync #(.W(LINE_CNT), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({cd_n, ri_n, dsr_n, cts_n}),
    .dout  (pins_sync_n)
  );

  modem_sts u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (sts_rd),
    .ext_lvl  (pins_to_lines(pins_sync_n)),
    .loop_en  (loop_en),
    .loop_ctl (ctl_bits),
    .rdata    (sts_rdata),
    .flags    (flags),
    .chg_evt  (chg_evt)
  );

  assign msi_req = msi_en & (|flags);

  // R7
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> ({usr2_n, usr1_n, rts_n, dtr_n} == 4'hF));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> (msi_en && sts_rdata[3:0] != 4'h0));

endmodule

// File: tb/sim_modem_ctl_unit.sv
`timescale 1ns/1ps
module sim_modem_ctl_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       sts_rd = 1'b0;
  logic [7:0] sts_rdata;
  logic       msi_en = 1'b0;
  logic       msi_req;
  logic       cd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
  logic       dtr_n, rts_n, usr1_n, usr2_n;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_ctl_unit u0 (.*);

  // {wdata, expected {usr2_n,usr1_n,rts_n,dtr_n}, expected readback}
  localparam logic [19:0] VEC [5] = '{
    {8'h01, 4'b1110, 8'h01},
    {8'h0A, 4'b0101, 8'h0A},
    {8'hE5, 4'b1010, 8'h05},
    {8'h0F, 4'b0000, 8'h0F},
    {8'h00, 4'b1111, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_sts(output logic [7:0] v);
    v = sts_rdata;
    sts_rd = 1'b1;
    tick(1);
    sts_rd = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {usr2_n, usr1_n, rts_n, dtr_n};
  endfunction

  initial begin
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 ctl readback", ctl_rdata, 8'h00);
    chk("R1 outputs", outs(), 4'hF);
    chk("R1 status", sts_rdata, 8'h00);
    chk("R1 irq", msi_req, 1'b0);

    foreach (VEC[i]) begin
      wr_ctl(VEC[i][19:12]);
      chk("R2 outputs", outs(), VEC[i][11:8]);
      chk("R2 readback", ctl_rdata, VEC[i][7:0]);
    end

    // carrier detect asserted
    cd_n = 1'b0;
    tick(2);
    chk("R3 not yet visible", sts_rdata, 8'h00);
    tick(1);
    chk("R3 R4 carrier change", sts_rdata, 8'h88);
    chk("R8 irq masked", msi_req, 1'b0);
    msi_en = 1'b1; #1;
    chk("R8 irq enabled", msi_req, 1'b1);
    rd_sts(v);
    chk("R6 read value", v, 8'h88);
    chk("R6 cleared", sts_rdata, 8'h80);
    chk("R8 irq drops", msi_req, 1'b0);

    // ring: falling pin sets nothing, rising pin sets trailing flag
    ri_n = 1'b0; tick(3);
    chk("R5 ring lead edge", sts_rdata, 8'hC0);
    ri_n = 1'b1; tick(3);
    chk("R5 ring trail edge", sts_rdata, 8'h84);
    tick(10);
    chk("R9 flag holds", sts_rdata, 8'h84);
    rd_sts(v);
    chk("R6 cleared after ring", sts_rdata, 8'h80);

    // change arrives at the same edge as the read
    dsr_n = 1'b0;
    tick(2);
    sts_rd = 1'b1;
    tick(1);
    sts_rd = 1'b0;
    chk("R6 set beats clear", sts_rdata, 8'hA2);
    rd_sts(v);
    chk("R6 cleared dsr", sts_rdata, 8'hA0);

    // loopback: dtr -> dsr only
    wr_ctl(8'h11);
    chk("R7 outputs parked", outs(), 4'hF);
    tick(1);
    chk("R7 loop dtr->dsr", sts_rdata, 8'h28);
    rd_sts(v);
    wr_ctl(8'h1F);
    chk("R7 outputs parked all", outs(), 4'hF);
    tick(1);
    chk("R7 loop all set", sts_rdata, 8'hF9);
    rd_sts(v);
    wr_ctl(8'h10);
    tick(1);
    chk("R7 R5 loop all clear", sts_rdata, 8'h0F);
    cts_n = 1'b0; tick(4);
    chk("R7 pin ignored", sts_rdata, 8'h0F);
    cts_n = 1'b1; tick(3);

    // leave loopback, pins take over again
    wr_ctl(8'h00);
    tick(1);
    chk("R3 R9 back to pins", sts_rdata, 8'hAF);
    chk("R2 outputs idle", outs(), 4'hF);
    msi_en = 1'b0; #1;
    chk("R8 irq masked again", msi_req, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule